// File: doc/BRIEF.md
# DMA Channel Interrupt Status Controller

This block keeps the interrupt state of one channel of a descriptor-driven DMA engine. Five sticky pending flags record what happened to the channel: normal completion, error completion, not-ready, channel abort and premature completion. Each flag has its own enable bit. Any flag that is set while its enable is set raises the single interrupt output. Firmware reads all flags and enables through one 32-bit register. It clears a flag by writing a 1 to that flag's bit. The enable bits are plain read/write bits.

The descriptor sequencer reports events to the block as one-cycle strobes. The block returns three flow signals to it. `stall` holds the sequencer on the current descriptor while an error is pending. `resume` pulses once when firmware clears the error, and the same descriptor is then retried from where it stopped. `advance` pulses once after an abort request, and the sequencer then drops the current descriptor and moves to the next. A per-descriptor "interrupt when done" flag can force the normal-completion flag even when that flag's enable bit is off.

Top module: `dma_chan_irq_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0 and `irq`, `stall`, `resume` and `advance` are all 0.
- R2: Register layout. The pending flags are normal completion at bit 31, error at 30, not-ready at 29, abort at 28 and premature at 27. The enables use the same order at bits 24 to 20. Bits 26:25 and 19:0 always read 0. A write loads bits 24:20 into the enables.
- R3: A write with a 1 at a pending bit position (31 to 27) clears that flag. A 0 at that position leaves the flag unchanged.
- R4: The normal-completion flag (bit 31) is set one cycle after `ev_desc_close` is high together with (`ev_len_zero` or `ev_periph_done`) and together with (enable bit 24 or `desc_idone`). The flag is not set if either condition is missing.
- R5: `ev_bad_desc_ptr` or `ev_bad_buf_ptr` sets the error flag (bit 30). `stall` equals that flag.
- R6: `resume` is high for exactly the one cycle after the error flag goes from 1 to 0.
- R7: `ev_abort_req` sets the abort flag (bit 28) and makes `advance` high for exactly the next cycle. When `resume` and `advance` would fall in the same cycle, only `advance` is issued.
- R8: `ev_not_ready` sets bit 29 and `ev_premature` sets bit 27.
- R9: `irq` is high exactly when some pending flag and its matching enable are both 1.
- R10: When a set event and a write-1 clear hit the same flag in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ev_desc_close | input | 1 | Current descriptor closed |
| ev_len_zero | input | 1 | Byte-length count reached zero |
| ev_periph_done | input | 1 | Peripheral signalled completion |
| ev_bad_desc_ptr | input | 1 | Invalid descriptor pointer met |
| ev_bad_buf_ptr | input | 1 | Invalid data buffer pointer met |
| ev_abort_req | input | 1 | Abort current descriptor |
| ev_not_ready | input | 1 | Not-ready condition strobe |
| ev_premature | input | 1 | Premature completion strobe |
| desc_idone | input | 1 | Current descriptor requests interrupt when done |
| irq | output | 1 | Channel interrupt |
| stall | output | 1 | Hold the sequencer on the current descriptor |
| resume | output | 1 | One-cycle retry pulse after error clear |
| advance | output | 1 | One-cycle skip-to-next pulse after abort |

## Verification
Some properties are checked on every cycle: `stall` follows the error bit, the interrupt matches the readable pending and enable fields, the reserved bits stay zero, `resume` and `advance` never occur together, and each error, abort and not-ready strobe shows up in the register one cycle later. Other behaviour can only be shown by the bench scenarios. These are the conditions under which normal completion is or is not recorded (enable versus the descriptor flag, and closes with no end condition), write-0 leaving flags untouched, the single-cycle width of `resume` after a long stall, and an abort that coincides with an error clear.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int NFLAG    = 5;
    localparam int REG_W    = 32;
    localparam int PEND_LSB = 27;
    localparam int EN_LSB   = 20;

    // flag indices, highest index maps to highest register bit
    localparam int FL_PC = 0;
    localparam int FL_CA = 1;
    localparam int FL_NR = 2;
    localparam int FL_EC = 3;
    localparam int FL_NC = 4;

    typedef logic [NFLAG-1:0] flag_vec_t;

    typedef struct packed {
        logic desc_close;
        logic len_zero;
        logic periph_done;
        logic bad_desc;
        logic bad_buf;
        logic abort_req;
        logic not_ready;
        logic premature;
        logic idone;
    } chan_evt_t;

    function automatic flag_vec_t pend_field(input logic [REG_W-1:0] w);
        return w[PEND_LSB +: NFLAG];
    endfunction

    function automatic flag_vec_t en_field(input logic [REG_W-1:0] w);
        return w[EN_LSB +: NFLAG];
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(input flag_vec_t p, input flag_vec_t e);
        logic [REG_W-1:0] r;
        r = '0;
        r[PEND_LSB +: NFLAG] = p;
        r[EN_LSB +: NFLAG]   = e;
        return r;
    endfunction
endpackage

// File: rtl/irq_event_decode.sv
module irq_event_decode
    import dma_irq_pkg::*;
(
    input  chan_evt_t evt,
    input  flag_vec_t en,
    output flag_vec_t set_vec
);
    logic normal_end;

    always_comb begin
        normal_end = evt.desc_close && (evt.len_zero || evt.periph_done);
        set_vec        = '0;
        set_vec[FL_NC] = normal_end && (en[FL_NC] || evt.idone);
        set_vec[FL_EC] = evt.bad_desc || evt.bad_buf;
        set_vec[FL_NR] = evt.not_ready;
        set_vec[FL_CA] = evt.abort_req;
        set_vec[FL_PC] = evt.premature;
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import dma_irq_pkg::*;
#(
    parameter int N = NFLAG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] en_wdata,
    input  logic [N-1:0] set_vec,
    output logic [N-1:0] pend,
    output logic [N-1:0] en
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // sticky pending bit: set has priority over write-1 clear
        always_ff @(posedge clk) begin
            if (rst)
                pend[i] <= 1'b0;
            else if (set_vec[i])
                pend[i] <= 1'b1;
            else if (wr_en && clr_bits[i])
                pend[i] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)
                en[i] <= 1'b0;
            else if (wr_en)
                en[i] <= en_wdata[i];
        end
    end
endmodule

// File: rtl/irq_flow_ctrl.sv
module irq_flow_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic err_flag,
    input  logic abort_req,
    output logic stall,
    output logic resume,
    output logic advance
);
    logic err_prev;
    logic adv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_prev <= 1'b0;
            adv_q    <= 1'b0;
        end else begin
            err_prev <= err_flag;
            adv_q    <= abort_req;
        end
    end

    assign stall   = err_flag;
    assign advance = adv_q;
    assign resume  = err_prev && !err_flag && !adv_q;
endmodule

// File: rtl/dma_chan_irq_ctrl.sv
module dma_chan_irq_ctrl
    import dma_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ev_desc_close,
    input  logic        ev_len_zero,
    input  logic        ev_periph_done,
    input  logic        ev_bad_desc_ptr,
    input  logic        ev_bad_buf_ptr,
    input  logic        ev_abort_req,
    input  logic        ev_not_ready,
    input  logic        ev_premature,
    input  logic        desc_idone,
    output logic        irq,
    output logic        stall,
    output logic        resume,
    output logic        advance
);
    chan_evt_t evt;
    flag_vec_t set_vec;
    flag_vec_t pend;
    flag_vec_t en;

    always_comb begin
        evt.desc_close  = ev_desc_close;
        evt.len_zero    = ev_len_zero;
        evt.periph_done = ev_periph_done;
        evt.bad_desc    = ev_bad_desc_ptr;
        evt.bad_buf     = ev_bad_buf_ptr;
        evt.abort_req   = ev_abort_req;
        evt.not_ready   = ev_not_ready;
        evt.premature   = ev_premature;
        evt.idone       = desc_idone;
    end

    irq_event_decode u_decode (
        .evt     (evt),
        .en      (en),
        .set_vec (set_vec)
    );

    irq_flag_bank #(.N(NFLAG)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .clr_bits (pend_field(reg_wdata)),
        .en_wdata (en_field(reg_wdata)),
        .set_vec  (set_vec),
        .pend     (pend),
        .en       (en)
    );

    irq_flow_ctrl u_flow (
        .clk       (clk),
        .rst       (rst),
        .err_flag  (pend[FL_EC]),
        .abort_req (ev_abort_req),
        .stall     (stall),
        .resume    (resume),
        .advance   (advance)
    );

    assign reg_rdata = pack_reg(pend, en);
    assign irq       = |(pend & en);
endmodule

// File: rtl/dma_chan_irq_chk.sv
module dma_chan_irq_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        ev_desc_close,
    input logic        ev_len_zero,
    input logic        ev_periph_done,
    input logic        ev_bad_desc_ptr,
    input logic        ev_bad_buf_ptr,
    input logic        ev_abort_req,
    input logic        ev_not_ready,
    input logic        ev_premature,
    input logic        desc_idone,
    input logic        irq,
    input logic        stall,
    input logic        resume,
    input logic        advance
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (reg_rdata == 32'h0 && !irq && !resume && !advance));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[26:25] == 2'b00 && reg_rdata[19:0] == 20'h0));

    // R5
    bad_ptr_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_bad_desc_ptr || ev_bad_buf_ptr) |=> (stall && reg_rdata[30]));

    // R5
    stall_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        stall == reg_rdata[30]);

    // R6
    resume_edge_chk: assert property (@(posedge clk) disable iff (rst)
        resume |-> (!stall && $past(stall)));

    // R7
    abort_advance_chk: assert property (@(posedge clk) disable iff (rst)
        ev_abort_req |=> (advance && reg_rdata[28]));

    // R7
    adv_prio_chk: assert property (@(posedge clk) disable iff (rst)
        !(resume && advance));

    // R9
    irq_combine_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (|(reg_rdata[31:27] & reg_rdata[24:20])));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ev_not_ready |=> reg_rdata[29]);
endmodule

bind dma_chan_irq_ctrl dma_chan_irq_chk u_chk (.*);

// File: tb/dma_chan_irq_ctrl_test.sv
module dma_chan_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic ev_desc_close = 0, ev_len_zero = 0, ev_periph_done = 0;
    logic ev_bad_desc_ptr = 0, ev_bad_buf_ptr = 0, ev_abort_req = 0;
    logic ev_not_ready = 0, ev_premature = 0, desc_idone = 0;
    logic irq, stall, resume, advance;

    int total = 0;
    int bad   = 0;

    localparam logic [31:0] B_NC = 32'h8000_0000;
    localparam logic [31:0] B_EC = 32'h4000_0000;
    localparam logic [31:0] B_NR = 32'h2000_0000;
    localparam logic [31:0] B_CA = 32'h1000_0000;
    localparam logic [31:0] B_PC = 32'h0800_0000;
    localparam logic [31:0] E_NC = 32'h0100_0000;
    localparam logic [31:0] E_CA = 32'h0020_0000;

    always #10 clk = ~clk;

    dma_chan_irq_ctrl uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        reg_wr = 0; reg_wdata = '0;
        ev_desc_close = 0; ev_len_zero = 0; ev_periph_done = 0;
        ev_bad_desc_ptr = 0; ev_bad_buf_ptr = 0; ev_abort_req = 0;
        ev_not_ready = 0; ev_premature = 0; desc_idone = 0;
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr = 1; reg_wdata = d;
        tick();
        clear_in();
    endtask

    task automatic t_reset();
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 outs", {28'h0, irq, stall, resume, advance}, 32'h0);
    endtask

    task automatic t_layout();
        wr(32'hFFFF_FFFF);
        chk("R2 enables all", reg_rdata, 32'h01F0_0000);
        wr(32'h0000_0000);
        chk("R2 enables off", reg_rdata, 32'h0);
    endtask

    task automatic t_normal();
        ev_desc_close = 1; ev_len_zero = 1; tick(); clear_in();
        chk("R4 no enable no idone", reg_rdata & B_NC, 32'h0);
        ev_desc_close = 1; desc_idone = 1; tick(); clear_in();
        chk("R4 close without end cond", reg_rdata & B_NC, 32'h0);
        ev_desc_close = 1; ev_periph_done = 1; desc_idone = 1; tick(); clear_in();
        chk("R4 idone forces flag", reg_rdata & B_NC, B_NC);
        chk("R9 flag without enable", {31'h0, irq}, 32'h0);
        wr(32'h0000_0000);
        chk("R3 write 0 keeps flag", reg_rdata & B_NC, B_NC);
        wr(B_NC);
        chk("R3 write 1 clears", reg_rdata, 32'h0);
        wr(E_NC);
        ev_desc_close = 1; ev_len_zero = 1; tick(); clear_in();
        chk("R4 enable path", reg_rdata, B_NC | E_NC);
        chk("R9 irq on", {31'h0, irq}, 32'h1);
        wr(B_NC | E_NC);
        chk("R3 clear keeps enable", reg_rdata, E_NC);
        chk("R9 irq off", {31'h0, irq}, 32'h0);
        wr(32'h0);
    endtask

    task automatic t_error();
        ev_bad_desc_ptr = 1; tick(); clear_in();
        chk("R5 bad desc flag", reg_rdata, B_EC);
        chk("R5 stall", {31'h0, stall}, 32'h1);
        tick(); tick(); tick();
        chk("R5 stall held", {31'h0, stall}, 32'h1);
        chk("R6 no resume while held", {31'h0, resume}, 32'h0);
        wr(B_EC);
        chk("R6 stall released", {31'h0, stall}, 32'h0);
        chk("R6 resume pulse", {31'h0, resume}, 32'h1);
        tick();
        chk("R6 resume one cycle", {31'h0, resume}, 32'h0);
        ev_bad_buf_ptr = 1; tick(); clear_in();
        chk("R5 bad buf flag", reg_rdata, B_EC);
        wr(B_EC);
        chk("R6 resume after buf", {31'h0, resume}, 32'h1);
        tick();
    endtask

    task automatic t_abort();
        ev_abort_req = 1; tick(); clear_in();
        chk("R7 abort flag", reg_rdata, B_CA);
        chk("R7 advance pulse", {31'h0, advance}, 32'h1);
        tick();
        chk("R7 advance one cycle", {31'h0, advance}, 32'h0);
        wr(B_CA);
        ev_bad_buf_ptr = 1; tick(); clear_in();
        reg_wr = 1; reg_wdata = B_EC; ev_abort_req = 1; tick(); clear_in();
        chk("R7 advance wins", {30'h0, advance, resume}, 32'h2);
        chk("R7 stall cleared", {31'h0, stall}, 32'h0);
        tick();
        chk("R7 both low after", {30'h0, advance, resume}, 32'h0);
        wr(B_CA);
    endtask

    task automatic t_other_flags();
        ev_not_ready = 1; tick(); clear_in();
        chk("R8 not ready", reg_rdata, B_NR);
        ev_premature = 1; tick(); clear_in();
        chk("R8 premature", reg_rdata, B_NR | B_PC);
        wr(B_NR | B_PC);
        chk("R8 cleared", reg_rdata, 32'h0);
    endtask

    task automatic t_irq_mask();
        wr(E_CA);
        ev_not_ready = 1; tick(); clear_in();
        chk("R9 masked flag", {31'h0, irq}, 32'h0);
        ev_abort_req = 1; tick(); clear_in();
        chk("R9 enabled flag", {31'h0, irq}, 32'h1);
        wr(B_NR | B_CA);
        chk("R9 cleared", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_set_wins();
        reg_wr = 1; reg_wdata = B_NR; ev_not_ready = 1; tick(); clear_in();
        chk("R10 set beats clear", reg_rdata & B_NR, B_NR);
        wr(B_NR);
        chk("R10 later clear", reg_rdata & B_NR, 32'h0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 0;
                t_reset();
                t_layout();
                t_normal();
                t_error();
                t_abort();
                t_other_flags();
                t_irq_mask();
                t_set_wins();
            end
            begin
                repeat (20000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule